// File: doc/BRIEF.md
# Prioritised Access Permission Checker

This block decides whether a memory access may proceed, given a set of protection entries whose inclusive lower and upper byte bounds have already been decoded elsewhere. Each entry also carries a small configuration word holding its read, write and execute permissions, its address-matching kind and a lock flag. For each request the block receives the access address, the access size in bytes, the rights being requested and the current privilege level. It returns a single allow or deny verdict one clock later.

All entries are compared in parallel. An entry that either covers the whole access or covers only one end of it is said to decide, and a priority encoder hands the verdict to the lowest-numbered deciding entry. Machine-level accesses skip the permission bits of unlocked entries and go through when no entry decides. An entry counts as locked when its own lock flag is set, or when the next entry up is locked and uses the top-of-range matching kind. When every entry is switched off, every access is allowed.

Top module: `perm_checker`

## Requirements
- R1: When every entry has matching kind OFF (configuration bits 4:3 equal 00), every valid request is allowed, including one that crosses an entry's bounds.
- R2: An entry covers a byte when lower bound <= byte address <= upper bound, with both bounds inclusive. The first byte tested is the request address and the last is address + size - 1, computed modulo 2^ADDR_W.
- R3: If exactly one of the first and last bytes lies inside an entry, that entry decides and the access is denied, whatever the entry's matching kind.
- R4: Only the deciding entry with the lowest index sets the verdict. Higher-indexed entries that would decide differently have no effect.
- R5: An entry whose matching kind is OFF and that covers both bytes does not decide.
- R6: A deciding entry that covers both bytes allows the access only when every requested right is among its allowed rights. Requested rights are bit0 read, bit1 write and bit2 execute. The allowed rights are all three for a machine-level request (mode 2'b11) to an unlocked entry; in every other case they are the entry's configuration bits 2:0, in the same bit order.
- R7: Entry i is locked when its configuration bit 5 is set, or when entry i+1 has bit 5 set and matching kind TOR (bits 4:3 equal 01). The highest entry uses only its own bit.
- R8: When at least one entry is active and no entry decides, a machine-level request is allowed and any other mode is denied.
- R9: `rsp_valid` equals `req_valid` delayed by one clock. `rsp_allow` takes a new verdict only after a valid request and otherwise holds its value. Both outputs are 0 while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Address of the first accessed byte |
| req_size | input | SIZE_W | Access size in bytes |
| req_rights | input | 3 | Requested rights: bit0 read, bit1 write, bit2 execute |
| req_mode | input | 2 | Privilege level; 2'b11 is machine level |
| ent_lo | input | N*ADDR_W | Inclusive lower bounds, entry i at bits [i*ADDR_W +: ADDR_W] |
| ent_hi | input | N*ADDR_W | Inclusive upper bounds, packed in the same way |
| ent_cfg | input | N*6 | Configuration per entry: bits 2:0 rights, 4:3 matching kind, 5 lock |
| rsp_valid | output | 1 | Verdict valid |
| rsp_allow | output | 1 | 1 allows the access, 0 denies it |

## Verification
A fixed set of four entries, two of which overlap, is driven with accesses that fall inside one entry, inside two overlapping entries with conflicting permissions, across an upper bound, on the exact last byte of a range, inside a switched-off entry only, and outside every entry. Each case is repeated at user and machine level. Together these separate priority order from straddle denial, locked permission bits from the machine-level bypass, and the no-match default from a match on a switched-off entry. Directed tests then change the configuration to turn every entry off, to lock an entry through its upper neighbour under TOR and under another matching kind, and to lock the highest entry. A final test checks that the verdict holds while no request is presented.

// File: rtl/perm_pkg.sv
`timescale 1ns/1ps
package perm_pkg;
  localparam int CFG_W    = 6;
  localparam int CFG_R    = 0;
  localparam int CFG_W_B  = 1;
  localparam int CFG_X    = 2;
  localparam int CFG_KLO  = 3;
  localparam int CFG_LOCK = 5;

  typedef enum logic [1:0] {
    MATCH_OFF   = 2'b00,
    MATCH_TOR   = 2'b01,
    MATCH_NA4   = 2'b10,
    MATCH_NAPOT = 2'b11
  } match_e;

  localparam logic [1:0] PRIV_MACHINE = 2'b11;
  localparam logic [2:0] RIGHTS_ALL   = 3'b111;
endpackage

// File: rtl/perm_entry.sv
`timescale 1ns/1ps
module perm_entry
  import perm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] first_b,
  input  logic [ADDR_W-1:0] last_b,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [2:0]        cfg_rights,
  input  match_e            kind,
  input  logic              own_lock,
  input  logic              next_tor_lock,
  input  logic [2:0]        want,
  input  logic              is_machine,
  output logic              decide,
  output logic              verdict
);
  logic       in_first;
  logic       in_last;
  logic       straddle;
  logic       covered;
  logic       locked;
  logic [2:0] granted;

  always_comb begin
    in_first = (first_b >= lo) && (first_b <= hi);
    in_last  = (last_b >= lo) && (last_b <= hi);
    straddle = in_first ^ in_last;
    covered  = in_first && in_last && (kind != MATCH_OFF);
    locked   = own_lock || next_tor_lock;
    granted  = (is_machine && !locked) ? RIGHTS_ALL : cfg_rights;
    decide   = straddle || covered;
    verdict  = !straddle && ((want & ~granted) == 3'b000);
  end
endmodule

// File: rtl/perm_prio.sv
`timescale 1ns/1ps
module perm_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/perm_checker.sv
`timescale 1ns/1ps
module perm_checker
  import perm_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [SIZE_W-1:0]     req_size,
  input  logic [2:0]            req_rights,
  input  logic [1:0]            req_mode,
  input  logic [N*ADDR_W-1:0]   ent_lo,
  input  logic [N*ADDR_W-1:0]   ent_hi,
  input  logic [N*CFG_W-1:0]    ent_cfg,
  output logic                  rsp_valid,
  output logic                  rsp_allow
);
  localparam int              PAD_W = ADDR_W - SIZE_W;
  localparam logic [ADDR_W-1:0] ONE_A = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] last_b;
  logic              is_machine;
  logic [N-1:0]      dec_vec;
  logic [N-1:0]      ver_vec;
  logic [N-1:0]      act_vec;
  logic [N-1:0]      pick_vec;
  logic              any_active;
  logic              allow_d;
  logic              valid_d;

  assign last_b     = req_addr + {{PAD_W{1'b0}}, req_size} - ONE_A;
  assign is_machine = (req_mode == PRIV_MACHINE);

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [CFG_W-1:0] cfg;
    match_e           kind;
    logic             nxt_lock;

    assign cfg        = ent_cfg[i*CFG_W +: CFG_W];
    assign kind       = match_e'(cfg[CFG_KLO +: 2]);
    assign act_vec[i] = (kind != MATCH_OFF);

    if (i < N-1) begin : g_nxt
      assign nxt_lock = ent_cfg[(i+1)*CFG_W + CFG_LOCK] &&
                        (ent_cfg[(i+1)*CFG_W + CFG_KLO +: 2] == MATCH_TOR);
    end else begin : g_top
      assign nxt_lock = 1'b0;
    end

    perm_entry #(.ADDR_W(ADDR_W)) u_ent (
      .first_b       (req_addr),
      .last_b        (last_b),
      .lo            (ent_lo[i*ADDR_W +: ADDR_W]),
      .hi            (ent_hi[i*ADDR_W +: ADDR_W]),
      .cfg_rights    ({cfg[CFG_X], cfg[CFG_W_B], cfg[CFG_R]}),
      .kind          (kind),
      .own_lock      (cfg[CFG_LOCK]),
      .next_tor_lock (nxt_lock),
      .want          (req_rights),
      .is_machine    (is_machine),
      .decide        (dec_vec[i]),
      .verdict       (ver_vec[i])
    );
  end

  perm_prio #(.N(N)) u_prio (
    .req   (dec_vec),
    .grant (pick_vec)
  );

  assign any_active = |act_vec;

  always_comb begin
    if (!any_active)
      allow_d = 1'b1;
    else if (|dec_vec)
      allow_d = |(pick_vec & ver_vec);
    else
      allow_d = is_machine;
    valid_d = req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
    end else begin
      rsp_valid <= valid_d;
      if (req_valid)
        rsp_allow <= allow_d;
    end
  end
endmodule

// File: rtl/perm_checker_sva.sv
`timescale 1ns/1ps
module perm_checker_sva #(
  parameter int N      = 4,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [SIZE_W-1:0] req_size,
  input logic [ADDR_W-1:0] lo0,
  input logic [ADDR_W-1:0] hi0,
  input logic              any_active,
  input logic [N-1:0]      dec_vec,
  input logic [N-1:0]      pick_vec,
  input logic              rsp_valid,
  input logic              rsp_allow
);
  logic [ADDR_W-1:0] end_b;
  logic              f_in;
  logic              l_in;

  assign end_b = req_addr + {{(ADDR_W-SIZE_W){1'b0}}, req_size} - {{(ADDR_W-1){1'b0}}, 1'b1};
  assign f_in  = (req_addr >= lo0) && (req_addr <= hi0);
  assign l_in  = (end_b >= lo0) && (end_b <= hi0);

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r9_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r9_allow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_allow));
  a_r4_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_vec));
  a_r4_pick_decides: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_vec & ~dec_vec) == '0);
  a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vec != '0) |-> ((pick_vec != '0) && ((dec_vec & (pick_vec - 1'b1)) == '0)));
  a_r1_no_rules: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !any_active) |=> rsp_allow);
  a_r3_first_straddle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && any_active && (f_in != l_in)) |=> !rsp_allow);
endmodule

bind perm_checker perm_checker_sva #(.N(N), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .req_size   (req_size),
  .lo0        (ent_lo[ADDR_W-1:0]),
  .hi0        (ent_hi[ADDR_W-1:0]),
  .any_active (any_active),
  .dec_vec    (dec_vec),
  .pick_vec   (pick_vec),
  .rsp_valid  (rsp_valid),
  .rsp_allow  (rsp_allow)
);

// File: tb/sim_perm_checker.sv
`timescale 1ns/1ps
module sim_perm_checker;
  localparam int N      = 4;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 4;
  localparam int NV     = 20;

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  size;
    logic [2:0]  rights;
    logic [1:0]  mode;
    logic        expect_allow;
  } vec_t;

  // entries: 0 [1000,10FF] R NAPOT; 1 [1000,1FFF] RW TOR;
  //          2 [3000,30FF] X NAPOT locked; 3 [4000,4FFF] RWX OFF
  localparam vec_t VT [NV] = '{
    '{32'h1000, 4'd4, 3'b001, 2'd0, 1'b1},  // R4 R6 entry 0 grants read
    '{32'h1000, 4'd4, 3'b010, 2'd0, 1'b0},  // R4 entry 0 refuses write before entry 1
    '{32'h1000, 4'd4, 3'b010, 2'd3, 1'b1},  // R6 machine bypass, unlocked
    '{32'h10FE, 4'd4, 3'b001, 2'd0, 1'b0},  // R3 straddle entry 0
    '{32'h10FE, 4'd4, 3'b001, 2'd3, 1'b0},  // R3 straddle, machine
    '{32'h1200, 4'd4, 3'b010, 2'd0, 1'b1},  // R4 entry 1 grants write
    '{32'h1200, 4'd4, 3'b100, 2'd0, 1'b0},  // R6 entry 1 refuses execute
    '{32'h3000, 4'd4, 3'b100, 2'd0, 1'b1},  // R6 entry 2 execute
    '{32'h3000, 4'd4, 3'b001, 2'd3, 1'b0},  // R7 locked entry, machine denied read
    '{32'h3000, 4'd4, 3'b100, 2'd3, 1'b1},  // R7 locked entry, machine execute
    '{32'h4000, 4'd4, 3'b001, 2'd0, 1'b0},  // R5 OFF entry does not decide, user
    '{32'h4000, 4'd4, 3'b001, 2'd3, 1'b1},  // R5 R8 no decider, machine
    '{32'h8000, 4'd4, 3'b001, 2'd1, 1'b0},  // R8 no match, supervisor
    '{32'h4FFE, 4'd4, 3'b001, 2'd3, 1'b0},  // R3 straddle on OFF entry
    '{32'h1FFE, 4'd4, 3'b001, 2'd3, 1'b0},  // R3 straddle on entry 1
    '{32'h1000, 4'd4, 3'b000, 2'd0, 1'b1},  // R6 empty request
    '{32'h1000, 4'd4, 3'b011, 2'd0, 1'b0},  // R6 partly granted
    '{32'h2FFF, 4'd1, 3'b001, 2'd0, 1'b0},  // R2 byte below entry 2
    '{32'h30FF, 4'd1, 3'b100, 2'd0, 1'b1},  // R2 inclusive upper byte
    '{32'h30FC, 4'd4, 3'b100, 2'd0, 1'b1}   // R2 last byte addr+size-1 = 30FF
  };

  logic                clk;
  logic                rst_n;
  logic                req_valid;
  logic [ADDR_W-1:0]   req_addr;
  logic [SIZE_W-1:0]   req_size;
  logic [2:0]          req_rights;
  logic [1:0]          req_mode;
  logic [N*ADDR_W-1:0] ent_lo;
  logic [N*ADDR_W-1:0] ent_hi;
  logic [N*6-1:0]      ent_cfg;
  logic                rsp_valid;
  logic                rsp_allow;

  int total;
  int bad;
  bit finished;

  perm_checker #(.N(N), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_rights(req_rights), .req_mode(req_mode),
    .ent_lo(ent_lo), .ent_hi(ent_hi), .ent_cfg(ent_cfg),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic request(input logic [31:0] a, input logic [3:0] s,
                         input logic [2:0] r, input logic [1:0] m);
    @(negedge clk);
    req_valid  = 1'b1;
    req_addr   = a;
    req_size   = s;
    req_rights = r;
    req_mode   = m;
    @(negedge clk);
    req_valid  = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    total = 0; bad = 0; finished = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = 4'd4;
    req_rights = 3'b000; req_mode = 2'd0;
    ent_lo  = {32'h4000, 32'h3000, 32'h1000, 32'h1000};
    ent_hi  = {32'h4FFF, 32'h30FF, 32'h1FFF, 32'h10FF};
    ent_cfg = {6'h07, 6'h3C, 6'h0B, 6'h19};
    repeat (3) @(negedge clk);
    check(rsp_valid, 1'b0, "R9 reset valid");
    check(rsp_allow, 1'b0, "R9 reset allow");
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      request(VT[k].addr, VT[k].size, VT[k].rights, VT[k].mode);
      check(rsp_valid, 1'b1, $sformatf("R9 vector %0d valid", k));
      check(rsp_allow, VT[k].expect_allow, $sformatf("vector %0d verdict", k));
    end

    // R9: idle cycle keeps previous verdict (last vector allowed)
    @(negedge clk);
    req_addr = 32'h8000; req_rights = 3'b111; req_mode = 2'd0;
    @(negedge clk);
    check(rsp_valid, 1'b0, "R9 idle valid low");
    check(rsp_allow, 1'b1, "R9 idle allow held");

    // R7: entry 1 locked with TOR locks entry 0
    ent_cfg = {6'h07, 6'h3C, 6'h2B, 6'h19};
    request(32'h1000, 4'd4, 3'b010, 2'd3);
    check(rsp_allow, 1'b0, "R7 TOR neighbour lock");
    // R7: entry 1 locked but NAPOT leaves entry 0 unlocked
    ent_cfg = {6'h07, 6'h3C, 6'h3B, 6'h19};
    request(32'h1000, 4'd4, 3'b010, 2'd3);
    check(rsp_allow, 1'b1, "R7 non-TOR neighbour");
    // R7: highest entry locked by own bit
    ent_cfg = {6'h39, 6'h3C, 6'h0B, 6'h19};
    request(32'h4000, 4'd4, 3'b100, 2'd3);
    check(rsp_allow, 1'b0, "R7 top entry own lock");
    request(32'h4000, 4'd4, 3'b001, 2'd3);
    check(rsp_allow, 1'b1, "R7 top entry read");

    // R1: every entry OFF
    ent_cfg = {6'h07, 6'h07, 6'h07, 6'h07};
    request(32'h8000, 4'd4, 3'b111, 2'd0);
    check(rsp_allow, 1'b1, "R1 no rules user");
    request(32'h10FE, 4'd4, 3'b001, 2'd0);
    check(rsp_allow, 1'b1, "R1 no rules straddle");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule